// File: doc/BRIEF.md
# Chained-MAC 32x32 Multiplier with Per-Operand Signedness

This block multiplies two 32-bit operands into a full 64-bit product with no clock and no registers. It splits each operand into two 16-bit halves and computes four 16x16 partial products. Each partial product comes from a multiply-accumulate stage that adds a 32-bit addend to its product and returns a 33-bit sum, with the carry in the top bit.

The stages are chained through their addend inputs, so no wide adder sums the partial products at the end:

- The low half of the first stage's sum goes straight to the output.
- Its high half feeds the second stage.
- The whole 32-bit result of the second stage feeds the third.
- The upper 17 bits of the third stage, including its carry, feed the fourth.

Two flags, one per operand, mark that operand as two's-complement. This gives the unsigned, mixed and signed forms that high-word multiply instructions need. A negative operand flagged as signed is handled by subtracting the other operand from the upper 32 bits of the result. The lower 32 bits never change with the flags.

Top module: `chained_mac_mult`

## Requirements
- R1: With both flags low, `prod_o` equals the 64-bit unsigned product of `a_i` and `b_i` (for example 0x5678 x 0xCDEF = 0x458ED208).
- R2: With both flags high, `prod_o` equals the two's-complement product of the sign-extended operands, modulo 2^64.
- R3: With `a_signed` high and `b_signed` low, `prod_o` equals the sign-extended `a_i` times the zero-extended `b_i`, modulo 2^64.
- R4: With `a_signed` low and `b_signed` high, `prod_o` equals the zero-extended `a_i` times the sign-extended `b_i`, modulo 2^64.
- R5: `prod_o[31:0]` equals the low 32 bits of the unsigned product whatever the two flags are.
- R6: The first, second and fourth stages never produce a carry out. This holds even for all-ones operands, where the full unsigned product is 0xFFFFFFFE00000001.
- R7: The carry of the third stage is passed on to the fourth stage. For all-ones operands the third stage's sum is 0x1FFFD0000, and the product still comes out correct.
- R8: A zero operand gives a zero product in every mode.
- R9: The output follows an input change in the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| a_signed | input | 1 | Treat `a_i` as two's-complement |
| b_signed | input | 1 | Treat `b_i` as two's-complement |
| prod_o | output | 64 | Full product |

## Verification
The assertions take the inputs to be settled, known two-state values whenever the combinational process that checks them runs. They compare the output against a wide reference product, so they assume no input can be X or Z. The bench drives every operand and flag from a defined value before it samples. It changes inputs only at the falling clock edge and checks one time unit later, so each check sees a stable operand set. Random operands come from a fixed-seed generator, and the flags cycle through all four modes.

// File: rtl/chained_mac_mult_pkg.sv
// Package: shared widths for the chained multiplier.
// Assumes operands are split into exactly two equal halves.
package chained_mac_mult_pkg;
    parameter int HALF_W = 16;
    parameter int OP_W   = 2 * HALF_W;
    parameter int PROD_W = 2 * OP_W;
    parameter int SUM_W  = OP_W + 1;
endpackage

// File: rtl/mac_stage.sv
// mac_stage: one multiply-accumulate stage. Forms mul_a*mul_b plus addend
// and returns the sum one bit wider than the addend, the top bit being the
// carry. Purely combinational; assumes unsigned inputs.
module mac_stage #(
    parameter int HW = 16,
    localparam int AW = 2 * HW,
    localparam int SW = AW + 1
) (
    input  logic [HW-1:0] mul_a,
    input  logic [HW-1:0] mul_b,
    input  logic [AW-1:0] addend,
    output logic [SW-1:0] sum
);
    logic [SW-1:0] product;

    // Widen and multiply, then accumulate the addend.
    always_comb begin
        product = SW'(mul_a) * SW'(mul_b);
        sum     = product + SW'(addend);
    end
endmodule

// File: rtl/sign_correct.sv
// sign_correct: turns the unsigned upper product word into the signed,
// mixed or unsigned upper word. For every operand flagged signed with its
// top bit set, the other operand is subtracted (the effect of its all-ones
// sign extension). Assumes the wrap above bit 63 is discarded.
module sign_correct #(
    parameter int OW = 32
) (
    input  logic [OW-1:0] upper_raw,
    input  logic [OW-1:0] op_a,
    input  logic [OW-1:0] op_b,
    input  logic          a_signed,
    input  logic          b_signed,
    output logic [OW-1:0] upper_fixed
);
    logic [OW-1:0] term [2];
    logic [1:0]    neg;
    logic [OW-1:0] other [2];

    assign neg      = {b_signed & op_b[OW-1], a_signed & op_a[OW-1]};
    assign other[0] = op_b;
    assign other[1] = op_a;

    for (genvar k = 0; k < 2; k++) begin : g_term
        // Select the amount to subtract for operand k.
        always_comb term[k] = neg[k] ? other[k] : '0;
    end

    // Apply both subtractions modulo 2^OW.
    always_comb upper_fixed = upper_raw - term[0] - term[1];
endmodule

// File: rtl/chained_mac_mult.sv
// chained_mac_mult: 32x32 to 64-bit multiplier built from four chained
// multiply-accumulate stages, with per-operand signedness. Combinational;
// assumes settled inputs. No clock or reset is used.
module chained_mac_mult
    import chained_mac_mult_pkg::*;
(
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic [PROD_W-1:0] prod_o
);
    logic [HALF_W-1:0] al, ah, bl, bh;
    logic [SUM_W-1:0]  s0_sum, s1_sum, s2_sum, s3_sum;
    logic [OP_W-1:0]   s1_add, s3_add, upper_fixed;

    // Split operands into halves.
    always_comb begin
        al = a_i[HALF_W-1:0];
        ah = a_i[OP_W-1:HALF_W];
        bl = b_i[HALF_W-1:0];
        bh = b_i[OP_W-1:HALF_W];
    end

    // Forward high parts into the next accumulate inputs.
    always_comb begin
        s1_add = OP_W'(s0_sum[OP_W-1:HALF_W]);
        s3_add = OP_W'(s2_sum[SUM_W-1:HALF_W]);
    end

    mac_stage #(.HW(HALF_W)) u_ll (.mul_a(al), .mul_b(bl), .addend('0),            .sum(s0_sum));
    mac_stage #(.HW(HALF_W)) u_hl (.mul_a(ah), .mul_b(bl), .addend(s1_add),        .sum(s1_sum));
    mac_stage #(.HW(HALF_W)) u_lh (.mul_a(al), .mul_b(bh), .addend(s1_sum[OP_W-1:0]), .sum(s2_sum));
    mac_stage #(.HW(HALF_W)) u_hh (.mul_a(ah), .mul_b(bh), .addend(s3_add),        .sum(s3_sum));

    sign_correct #(.OW(OP_W)) u_fix (
        .upper_raw  (s3_sum[OP_W-1:0]),
        .op_a       (a_i),
        .op_b       (b_i),
        .a_signed   (a_signed),
        .b_signed   (b_signed),
        .upper_fixed(upper_fixed)
    );

    // Assemble the 64-bit product from the stage outputs.
    always_comb prod_o = {upper_fixed, s2_sum[HALF_W-1:0], s0_sum[HALF_W-1:0]};
endmodule

// File: rtl/chained_mac_mult_chk.sv
// chained_mac_mult_chk: immediate assertions on the multiplier, attached by
// bind. Assumes two-state settled inputs when evaluated.
module chained_mac_mult_chk (
    input logic [31:0] a_i,
    input logic [31:0] b_i,
    input logic        a_signed,
    input logic        b_signed,
    input logic [63:0] prod_o,
    input logic        carry0,
    input logic        carry1,
    input logic        carry3
);
    logic [63:0] a_ext, b_ext, ref_prod, uns_prod;

    // Build the reference products from the ports.
    always_comb begin
        a_ext    = {{32{a_signed & a_i[31]}}, a_i};
        b_ext    = {{32{b_signed & b_i[31]}}, b_i};
        ref_prod = a_ext * b_ext;
        uns_prod = 64'(a_i) * 64'(b_i);
    end

    // Compare the output with the references.
    always_comb begin
        AST_UNSIGNED: assert (a_signed || b_signed || prod_o == uns_prod) else $error("unsigned product");       // R1
        AST_SIGNED: assert (!(a_signed && b_signed) || prod_o == ref_prod) else $error("signed product");      // R2
        AST_MIXED_A: assert (!(a_signed && !b_signed) || prod_o == ref_prod) else $error("mixed a product");   // R3
        AST_MIXED_B: assert (!(!a_signed && b_signed) || prod_o == ref_prod) else $error("mixed b product");   // R4
        AST_LOW_WORD: assert (prod_o[31:0] == uns_prod[31:0]) else $error("low word");                        // R5
        AST_NO_OVERFLOW: assert (!carry0 && !carry1 && !carry3) else $error("stage carry");                   // R6
        AST_ZERO_OPERAND: assert (!(a_i == 32'd0 || b_i == 32'd0) || prod_o == 64'd0) else $error("zero");   // R8
    end
endmodule

bind chained_mac_mult chained_mac_mult_chk u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .a_signed(a_signed),
    .b_signed(b_signed),
    .prod_o  (prod_o),
    .carry0  (s0_sum[32]),
    .carry1  (s1_sum[32]),
    .carry3  (s3_sum[32])
);

// File: tb/chained_mac_mult_test.sv
// chained_mac_mult_test: directed corners plus fixed-seed random vectors,
// checked against a bench reference product.
module chained_mac_mult_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        a_signed = 1'b0, b_signed = 1'b0;
    logic [63:0] prod_o;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    chained_mac_mult uut (.a_i(a_i), .b_i(b_i), .a_signed(a_signed), .b_signed(b_signed), .prod_o(prod_o));

    always #2 clk = ~clk;

    // Reference product from the requirements.
    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input logic sa, input logic sb);
        logic [63:0] ea, eb;
        ea = {{32{sa & a[31]}}, a};
        eb = {{32{sb & b[31]}}, b};
        return ea * eb;
    endfunction

    function automatic string mode_tag(input logic sa, input logic sb);
        if (sa && sb) return "R2";
        if (sa) return "R3";
        if (sb) return "R4";
        return "R1";
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at the falling edge, sample one time unit later.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic sa, input logic sb);
        @(negedge clk);
        a_i = a; b_i = b; a_signed = sa; b_signed = sb;
        #1;
    endtask

    task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input logic sa, input logic sb);
        apply(a, b, sa, sb);
        check(mode_tag(sa, sb), prod_o, ref_mul(a, b, sa, sb));
        check("R5", {32'd0, prod_o[31:0]}, {32'd0, 32'(a * b)});
        if (a == 32'd0 || b == 32'd0) check("R8", prod_o, 64'd0);
    endtask

    initial begin
        logic [31:0] corner [5];
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'hFFFF_FFFF;
        corner[3] = 32'h8000_0000; corner[4] = 32'h7FFF_FFFF;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check("R8", prod_o, 64'd0);                                      // idle zero inputs
        apply(32'h5678, 32'hCDEF, 1'b0, 1'b0);
        check("R1", prod_o, 64'h0000_0000_458E_D208);
        apply(32'h1234, 32'h90AB, 1'b0, 1'b0);
        check("R1", prod_o, 64'h0000_0000_0A49_68BC);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
        check("R6", prod_o, 64'hFFFF_FFFE_0000_0001);
        check("R7", prod_o, ref_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0));
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
        check("R2", prod_o, 64'd1);
        // R9: input change reflected without any clock edge.
        a_i = 32'd3; b_i = 32'd5; a_signed = 1'b0; b_signed = 1'b0;
        #0.5;
        check("R9", prod_o, 64'd15);
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    run_vec(corner[i], corner[j], m[1], m[0]);
        for (int r = 0; r < 400; r++)
            run_vec($urandom, $urandom, r[1], r[0]);
        run_vec(32'h1234_5678, 32'h90AB_CDEF, 1'b1, 1'b1);
        run_vec(32'h1234_5678, 32'h90AB_CDEF, 1'b0, 1'b1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule